// File: doc/BRIEF.md
# Return-Address Stack with Register Access

This block is the call/return stack of a small processor core. It stores up to thirty-one 21-bit program-counter values. The core uses it in two ways. A call request saves the PC value on the `pc_in` port. A return request hands back the saved address on `ret_addr`. Explicit push and pop commands do the same thing without the branch.

Software can reach the stack through a byte-wide register port. Four registers are selected by a 2-bit code:

| Code | Register |
|------|----------|
| 0 | Low byte of the top entry |
| 1 | High byte of the top entry |
| 2 | Upper five bits of the top entry |
| 3 | Stack pointer |

Both the pointer and the top entry can be written. This lets software move the pointer to any slot and inspect it, or replace a pending return address so that the next return goes somewhere else.

Pointer value zero does not select storage. It always reads as an all-zero entry. Sticky flags record an attempt to push past the last slot or to pop below slot zero.

Top module: `ret_addr_stack`

## Requirements
- R1: After reset the pointer is 0, both flags are 0, and the top entry reads 0.
- R2: While the pointer is 0 the top entry reads 0x000000, and writes to register codes 0, 1 or 2 are ignored.
- R3: A pointer write (code 3, data bits 4:0) takes effect at the clock edge. From the next cycle `tos` and `reg_rdata` show the entry at the new address. Reads return {3'b0, bits 20:16} for code 2 and {3'b0, pointer} for code 3.
- R4: A write to code 0, 1 or 2 replaces bits 7:0, 15:8 or 20:16 (from data bits 4:0) of the entry at the current pointer. The other bits of that entry are left unchanged.
- R5: A call or push first increments the pointer, then stores `pc_in` in the new top slot.
- R6: A pop only decrements the pointer. The old entry stays in its slot and reads back if the pointer is written to that slot again.
- R7: During a return request, `ret_addr` shows the current top entry in the same cycle, and the pointer decrements at the edge. Without a return request, `ret_addr` is 0.
- R8: A call or push while the pointer is 0x1F sets the sticky `overflow` flag. The pointer and the stored entries are left unchanged.
- R9: A return or pop while the pointer is 0 sets the sticky `underflow` flag and leaves the pointer at 0. A return in that case gives `ret_addr` 0.
- R10: A register write in the same cycle as any core request is dropped.
- R11: When a push-class request (call or push) and a pop-class request (return or pop) arrive together, the push is performed and the pop is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_call | input | 1 | Call request: push `pc_in` |
| core_ret | input | 1 | Return request: output top, then pop |
| cmd_push | input | 1 | Explicit push of `pc_in` |
| cmd_pop | input | 1 | Explicit pop, discarding the top |
| pc_in | input | 21 | PC value to be saved |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register code (0 low, 1 high, 2 upper, 3 pointer) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| ret_addr | output | 21 | Return target during a return request |
| sp | output | 5 | Current stack pointer |
| tos | output | 21 | Current top entry |
| overflow | output | 1 | Sticky push-overflow flag |
| underflow | output | 1 | Sticky pop-underflow flag |

## Verification
A corrupted pointer shows on `sp` one cycle after the faulty edge. It also changes `tos` in that same cycle, because the top entry is selected combinationally from the pointer. A slot written at the wrong address, or a byte merged into the wrong field, stays hidden until the pointer comes back to that slot. The bench therefore revisits slots with pointer writes and after pops. A flag that is set or cleared wrongly is visible on the next cycle. Because the flags are sticky, the bench tracks them across the whole run and not per test.

// File: rtl/rstk_pkg.sv
package rstk_pkg;
  localparam int unsigned STK_AW = 5;
  localparam int unsigned STK_EW = 21;
  localparam int unsigned UPPER_W = STK_EW - 16;

  typedef enum logic [1:0] {
    SEL_LO  = 2'd0,
    SEL_HI  = 2'd1,
    SEL_UP  = 2'd2,
    SEL_PTR = 2'd3
  } reg_sel_e;

  function automatic logic [STK_EW-1:0] merge_field(
    input logic [STK_EW-1:0] old_val,
    input logic [1:0]        sel,
    input logic [7:0]        d
  );
    logic [STK_EW-1:0] r;
    r = old_val;
    case (sel)
      SEL_LO:  r[7:0]         = d;
      SEL_HI:  r[15:8]        = d;
      SEL_UP:  r[STK_EW-1:16] = d[UPPER_W-1:0];
      default: r              = old_val;
    endcase
    return r;
  endfunction

  function automatic logic [STK_AW-1:0] ptr_step_up(input logic [STK_AW-1:0] p);
    return p + 1'b1;
  endfunction

  function automatic logic [STK_AW-1:0] ptr_step_down(input logic [STK_AW-1:0] p);
    return p - 1'b1;
  endfunction
endpackage

// File: rtl/rstk_ptr.sv
module rstk_ptr
  import rstk_pkg::*;
#(
  parameter int unsigned AW = STK_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic          ptr_wr,
  input  logic [AW-1:0] ptr_wdata,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] push_addr,
  output logic          push_fire,
  output logic          ovf,
  output logic          unf
);
  localparam logic [AW-1:0] PTR_MAX = {AW{1'b1}};

  logic at_top, at_bottom, pop_fire, ovf_event, unf_event;

  assign at_top    = (sp == PTR_MAX);
  assign at_bottom = (sp == '0);
  assign push_fire = push_req && !at_top;
  assign ovf_event = push_req && at_top;
  assign pop_fire  = pop_req && !push_req && !at_bottom;
  assign unf_event = pop_req && !push_req && at_bottom;
  assign push_addr = ptr_step_up(sp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp  <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
    end else begin
      if (push_fire)     sp <= push_addr;
      else if (pop_fire) sp <= ptr_step_down(sp);
      else if (ptr_wr)   sp <= ptr_wdata;
      if (ovf_event) ovf <= 1'b1;
      if (unf_event) unf <= 1'b1;
    end
  end
endmodule

// File: rtl/rstk_array.sv
module rstk_array
  import rstk_pkg::*;
#(
  parameter int unsigned AW = STK_AW,
  parameter int unsigned EW = STK_EW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] sp,
  input  logic [AW-1:0] push_addr,
  input  logic          push_fire,
  input  logic [EW-1:0] pc_in,
  input  logic          tos_wr,
  input  logic [1:0]    tos_sel,
  input  logic [7:0]    wdata,
  output logic [EW-1:0] tos
);
  localparam int unsigned DEPTH = 2 ** AW;

  logic [EW-1:0] ent [DEPTH];

  assign ent[0] = '0;

  for (genvar i = 1; i < DEPTH; i++) begin : g_slot
    logic hit_push, hit_sw;
    assign hit_push = push_fire && (push_addr == AW'(i));
    assign hit_sw   = tos_wr && (sp == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ent[i] <= '0;
      else if (hit_push) ent[i] <= pc_in;
      else if (hit_sw)   ent[i] <= merge_field(ent[i], tos_sel, wdata);
    end
  end

  assign tos = ent[sp];
endmodule

// File: rtl/rstk_regif.sv
module rstk_regif
  import rstk_pkg::*;
#(
  parameter int unsigned AW = STK_AW,
  parameter int unsigned EW = STK_EW
) (
  input  logic          reg_wr_en,
  input  logic [1:0]    reg_sel,
  input  logic          core_busy,
  input  logic [AW-1:0] sp,
  input  logic [EW-1:0] tos,
  output logic          ptr_wr,
  output logic          tos_wr,
  output logic [7:0]    reg_rdata
);
  logic wr_ok;

  assign wr_ok  = reg_wr_en && !core_busy;
  assign ptr_wr = wr_ok && (reg_sel == SEL_PTR);
  assign tos_wr = wr_ok && (reg_sel != SEL_PTR) && (sp != '0);

  always_comb begin
    case (reg_sel)
      SEL_LO:  reg_rdata = tos[7:0];
      SEL_HI:  reg_rdata = tos[15:8];
      SEL_UP:  reg_rdata = 8'(tos[EW-1:16]);
      default: reg_rdata = 8'(sp);
    endcase
  end
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
  import rstk_pkg::*;
#(
  parameter int unsigned AW = STK_AW,
  parameter int unsigned EW = STK_EW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          core_call,
  input  logic          core_ret,
  input  logic          cmd_push,
  input  logic          cmd_pop,
  input  logic [EW-1:0] pc_in,
  input  logic          reg_wr_en,
  input  logic [1:0]    reg_sel,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic [EW-1:0] ret_addr,
  output logic [AW-1:0] sp,
  output logic [EW-1:0] tos,
  output logic          overflow,
  output logic          underflow
);
  logic          push_req, pop_req, core_busy;
  logic          ptr_wr, tos_wr, push_fire;
  logic [AW-1:0] push_addr;

  assign push_req  = core_call || cmd_push;
  assign pop_req   = core_ret || cmd_pop;
  assign core_busy = push_req || pop_req;
  assign ret_addr  = core_ret ? tos : '0;

  rstk_ptr #(.AW(AW)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_req  (push_req),
    .pop_req   (pop_req),
    .ptr_wr    (ptr_wr),
    .ptr_wdata (reg_wdata[AW-1:0]),
    .sp        (sp),
    .push_addr (push_addr),
    .push_fire (push_fire),
    .ovf       (overflow),
    .unf       (underflow)
  );

  rstk_array #(.AW(AW), .EW(EW)) u_arr (
    .clk       (clk),
    .rst_n     (rst_n),
    .sp        (sp),
    .push_addr (push_addr),
    .push_fire (push_fire),
    .pc_in     (pc_in),
    .tos_wr    (tos_wr),
    .tos_sel   (reg_sel),
    .wdata     (reg_wdata),
    .tos       (tos)
  );

  rstk_regif #(.AW(AW), .EW(EW)) u_rif (
    .reg_wr_en (reg_wr_en),
    .reg_sel   (reg_sel),
    .core_busy (core_busy),
    .sp        (sp),
    .tos       (tos),
    .ptr_wr    (ptr_wr),
    .tos_wr    (tos_wr),
    .reg_rdata (reg_rdata)
  );
endmodule

// File: rtl/rstk_checker.sv
module rstk_checker #(
  parameter int unsigned AW = 5,
  parameter int unsigned EW = 21
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_req,
  input logic          pop_req,
  input logic          core_ret,
  input logic          tos_wr,
  input logic          ptr_wr,
  input logic [EW-1:0] pc_in,
  input logic [AW-1:0] sp,
  input logic [EW-1:0] tos,
  input logic [EW-1:0] ret_addr,
  input logic          overflow,
  input logic          underflow
);
  localparam logic [AW-1:0] TOPP = {AW{1'b1}};

  a_r2_zero_slot: assert property (@(posedge clk) disable iff (!rst_n)
    sp == '0 |-> tos == '0);

  a_r5_push_store: assert property (@(posedge clk) disable iff (!rst_n)
    push_req && sp != TOPP |=> sp == $past(sp) + 1'b1 && tos == $past(pc_in));

  a_r6_pop_dec: assert property (@(posedge clk) disable iff (!rst_n)
    pop_req && !push_req && sp != '0 |=> sp == $past(sp) - 1'b1);

  a_r7_ret_value: assert property (@(posedge clk) disable iff (!rst_n)
    core_ret |-> ret_addr == tos);

  a_r8_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push_req && sp == TOPP |=> overflow && sp == TOPP && $stable(tos));

  a_r9_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop_req && !push_req && sp == '0 |=> underflow && sp == '0);

  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  a_r9_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);

  a_r10_core_first: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req || pop_req) |-> !tos_wr && !ptr_wr);
endmodule

bind ret_addr_stack rstk_checker #(.AW(AW), .EW(EW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .push_req  (push_req),
  .pop_req   (pop_req),
  .core_ret  (core_ret),
  .tos_wr    (tos_wr),
  .ptr_wr    (ptr_wr),
  .pc_in     (pc_in),
  .sp        (sp),
  .tos       (tos),
  .ret_addr  (ret_addr),
  .overflow  (overflow),
  .underflow (underflow)
);

// File: tb/ret_addr_stack_bench.sv
module ret_addr_stack_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        core_call = 0, core_ret = 0, cmd_push = 0, cmd_pop = 0;
  logic [20:0] pc_in = '0;
  logic        reg_wr_en = 0;
  logic [1:0]  reg_sel = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [20:0] ret_addr, tos;
  logic [4:0]  sp;
  logic        overflow, underflow;

  always #10 clk = ~clk;

  ret_addr_stack u_ret_addr_stack (
    .clk(clk), .rst_n(rst_n), .core_call(core_call), .core_ret(core_ret),
    .cmd_push(cmd_push), .cmd_pop(cmd_pop), .pc_in(pc_in),
    .reg_wr_en(reg_wr_en), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ret_addr(ret_addr), .sp(sp), .tos(tos),
    .overflow(overflow), .underflow(underflow)
  );

  typedef struct {
    string       tag;
    logic [4:0]  e_sp;
    logic [20:0] e_tos;
    logic        e_ovf;
    logic        e_unf;
  } exp_t;

  exp_t        sb_q[$];
  int          n_checks = 0;
  int          n_errs = 0;
  logic [20:0] mm [32];
  logic [4:0]  msp = '0;
  logic        movf = 0, munf = 0;

  function automatic logic [20:0] m_top();
    return (msp == 5'd0) ? 21'd0 : mm[msp];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected state and compares it with the outputs
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check({e.tag, " sp"}, 32'(sp), 32'(e.e_sp));
      check({e.tag, " tos"}, 32'(tos), 32'(e.e_tos));
      check({e.tag, " ovf"}, 32'(overflow), 32'(e.e_ovf));
      check({e.tag, " unf"}, 32'(underflow), 32'(e.e_unf));
    end
  end

  // Driver: applies one cycle of stimulus, updates the model, queues the expectation
  task automatic step(input string tag, input logic call, input logic ret,
                      input logic psh, input logic pop, input logic wr,
                      input logic [1:0] sel, input logic [7:0] wd, input logic [20:0] pc);
    logic pushc, popc;
    @(negedge clk); #5;
    core_call = call; core_ret = ret; cmd_push = psh; cmd_pop = pop;
    reg_wr_en = wr; reg_sel = sel; reg_wdata = wd; pc_in = pc;
    #1;
    if (ret) check({tag, " ret_addr (R7)"}, 32'(ret_addr), 32'(m_top()));
    else     check({tag, " ret_addr idle (R7)"}, 32'(ret_addr), 32'd0);
    pushc = call | psh;
    popc  = ret | pop;
    if (pushc) begin
      if (msp == 5'h1F) movf = 1'b1;
      else begin msp = msp + 5'd1; mm[msp] = pc; end
    end else if (popc) begin
      if (msp == 5'd0) munf = 1'b1;
      else msp = msp - 5'd1;
    end else if (wr) begin
      if (sel == 2'd3) msp = wd[4:0];
      else if (msp != 5'd0) begin
        case (sel)
          2'd0: mm[msp][7:0]   = wd;
          2'd1: mm[msp][15:8]  = wd;
          default: mm[msp][20:16] = wd[4:0];
        endcase
      end
    end
    @(posedge clk); #2;
    core_call = 0; core_ret = 0; cmd_push = 0; cmd_pop = 0; reg_wr_en = 0;
    sb_q.push_back('{tag, msp, m_top(), movf, munf});
  endtask

  task automatic rd(input string tag, input logic [1:0] sel);
    logic [7:0] e;
    @(negedge clk); #5;
    reg_sel = sel;
    #1;
    case (sel)
      2'd0: e = m_top() & 21'hFF;
      2'd1: e = 8'(m_top() >> 8);
      2'd2: e = 8'(m_top() >> 16);
      default: e = {3'b000, msp};
    endcase
    check(tag, 32'(reg_rdata), 32'(e));
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mm[i] = '0;
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset sp", 32'(sp), 0);
    check("R1 reset tos", 32'(tos), 0);
    check("R1 reset flags", {30'd0, overflow, underflow}, 0);

    step("R2 tos write at slot0", 0,0,0,0, 1, 2'd0, 8'hAB, 0);
    rd("R2 low read at slot0", 2'd0);
    step("R9 return at empty", 0,1,0,0, 0, 2'd0, 0, 0);
    step("R9 pop at empty", 0,0,0,1, 0, 2'd0, 0, 0);

    step("R5 push a", 0,0,1,0, 0, 0, 0, 21'h1_2345);
    step("R5 call b", 1,0,0,0, 0, 0, 0, 21'h0_ABCD);
    step("R5 push c", 0,0,1,0, 0, 0, 0, 21'h1F_FFFF);
    step("R4 low byte", 0,0,0,0, 1, 2'd0, 8'h5A, 0);
    step("R4 high byte", 0,0,0,0, 1, 2'd1, 8'hC3, 0);
    step("R4 upper bits", 0,0,0,0, 1, 2'd2, 8'hE4, 0);
    rd("R3 read upper", 2'd2);
    rd("R3 read high", 2'd1);
    rd("R3 read ptr", 2'd3);
    step("R7 return", 0,1,0,0, 0, 0, 0, 0);
    step("R6 pop", 0,0,0,1, 0, 0, 0, 0);
    step("R3 ptr write 3", 0,0,0,0, 1, 2'd3, 8'h03, 0);
    step("R6 ptr write 2 old entry", 0,0,0,0, 1, 2'd3, 8'hE2, 0);
    rd("R3 read low", 2'd0);

    step("R10 ptr write vs push", 0,0,1,0, 1, 2'd3, 8'h10, 21'h0_0777);
    step("R10 tos write vs pop", 0,0,0,1, 1, 2'd0, 8'h99, 0);
    step("R11 push and pop", 0,0,1,1, 0, 0, 0, 21'h0_4242);
    step("R11 call and return", 1,1,0,0, 0, 0, 0, 21'h1_0101);

    step("R3 ptr to 1E", 0,0,0,0, 1, 2'd3, 8'h1E, 0);
    step("R5 push to 1F", 0,0,1,0, 0, 0, 0, 21'h0_1F1F);
    step("R8 push at full", 0,0,1,0, 0, 0, 0, 21'h0_DEAD);
    step("R8 call at full", 1,0,0,0, 0, 0, 0, 21'h0_BEEF);
    step("R7 return from full", 0,1,0,0, 0, 0, 0, 0);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_errs++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule